// File: doc/BRIEF.md
# Serial Port Model for a 14-bit Sampling Converter

This block is the device side of the frame-based serial port of a 14-bit sampling converter. It runs on a fast system clock. The host drives an active-low frame select and a serial clock, and both pass through synchronizers inside the block. Each frame samples the parallel code that a stub converter core presents. The block shifts out the result of the previous frame, MSB first, on a tri-stateable data line.

The block counts the falling serial-clock edges in each frame and uses that count alone to choose what happens:

- A frame of 18 edges completes a conversion.
- If the first frame after reset reaches 24 edges, the block runs a power-up offset calibration.
- Any later frame that reaches 64 edges runs a run-time offset calibration.

Calibration stores an offset code. From then on, every conversion result has that offset subtracted, with saturation to the 14-bit two's-complement range. If a frame ends before 18 edges, the next frame flags its data as invalid. The serial clock must run at no more than a quarter of the system clock rate.

Top module: `sar_serial_port`

## Requirements
- R1: After reset, `mode` is ACQ (2'b00), `sdo_oe` and `data_bad` are 0, and the result word sent in the first frame is all zeros.
- R2: The block detects a falling edge of `cs_n`. On that edge it moves `mode` to CONV (2'b01) and captures `core_code` as the frame's sample.
- R3: While `cs_n` is high, `sdo_oe` is 0. When `cs_n` falls, `sdo_oe` goes to 1 and `sdo` drives a single 0.
- R4: The MSB (bit 13) of the previous result appears on `sdo` after the rising edge of `sclk` that follows falling edge 1. Bit 13-(k-1) follows falling edge k, for k = 1 to 14. From then on, every rising edge drives 0.
- R5: At falling edge 18 of a frame, the corrected sample becomes the result sent in the next frame. Outside the first frame after reset, `mode` then returns to ACQ.
- R6: A frame that ends with fewer than 18 falling edges leaves the stored result unchanged. The next frame drives `data_bad` = 1 from its `cs_n` fall to its `cs_n` rise.
- R7: In the first frame after reset, falling edge 24 sets `mode` to CAL (2'b10). The whole frame shifts zeros.
- R8: In any later frame, falling edge 64 sets `mode` to CAL. The previous result still goes out first, and zeros follow it.
- R9: Calibration is aborted, leaving the offset unchanged and `mode` in ACQ after `cs_n` rises, in two cases. The first is a `cs_n` rise before edge 24 in the first frame. The second is a `cs_n` rise after more than 18 but fewer than 64 edges in a later frame.
- R10: A calibration stores `core_code` at its threshold edge as the offset. Later results are the sample minus that offset, clamped to 0x2000 (most negative) through 0x1FFF (most positive). The offset is cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low frame select from host (asynchronous) |
| sclk | input | 1 | Serial clock from host (asynchronous), idle high |
| core_code | input | 14 | Two's-complement code from the stub converter core |
| sdo | output | 1 | Serial data out, valid while `sdo_oe` is 1 |
| sdo_oe | output | 1 | Output enable for the tri-state data pad |
| data_bad | output | 1 | The word being sent is invalid (previous frame too short) |
| mode | output | 2 | 00 ACQ, 01 CONV, 10 CAL |

## Verification
Two things happen together in every frame of 18 or more clocks. The result register is rewritten at falling edge 18, while the shifter is still streaming the word captured at the frame's start. The bench therefore checks the serial word of each frame against the model's previous result, never against the value just converted. The 64-clock frames add a second overlap: the offset is captured and the mode changes on an edge where the edge counter saturates. This is judged by the corrected codes seen in the frames that follow.

// File: rtl/sar_port_pkg.sv
package sar_port_pkg;
   typedef enum logic [1:0] {
      M_ACQ  = 2'b00,
      M_CONV = 2'b01,
      M_CAL  = 2'b10
   } mode_e;
endpackage

// File: rtl/sar_in_sync.sv
module sar_in_sync #(
   parameter int   STAGES = 2,
   parameter logic INIT   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise,
   output logic fall
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sar_in_sync: STAGES must be at least 2");
   end

   // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {(STAGES+1){INIT}};
      else        chain <= {chain[STAGES-1:0], pin};
   end

   assign rise =  chain[STAGES-1] & ~chain[STAGES];
   assign fall = ~chain[STAGES-1] &  chain[STAGES];
endmodule

// File: rtl/sar_frame_ctrl.sv
module sar_frame_ctrl
   import sar_port_pkg::*;
#(
   parameter int DATA_W      = 14,
   parameter int CONV_EDGES  = 18,
   parameter int PWRUP_EDGES = 24,
   parameter int RUN_EDGES   = 64,
   localparam int CNT_W      = $clog2(RUN_EDGES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_fall,
   input  logic              cs_rise,
   input  logic              sclk_fall,
   input  logic [DATA_W-1:0] core_code,
   output mode_e             mode_o,
   output logic              frame_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic [DATA_W-1:0] result_o,
   output logic              short_o
);
   localparam logic [DATA_W-1:0] NEG_FS = {1'b1, {(DATA_W-1){1'b0}}};
   localparam logic [DATA_W-1:0] POS_FS = {1'b0, {(DATA_W-1){1'b1}}};

   mode_e             mode_q;
   logic              frame_q, first_q, short_q;
   logic [CNT_W-1:0]  cnt_q, cnt_nxt;
   logic [DATA_W-1:0] samp_q, offset_q, result_q, corr;
   logic [DATA_W:0]   diff;
   logic              step, conv_hit, cal_hit;

   assign cnt_nxt = cnt_q + 1'b1;
   assign step    = frame_q && sclk_fall && (cnt_q != CNT_W'(RUN_EDGES));
   assign conv_hit = step && (cnt_nxt == CNT_W'(CONV_EDGES));
   assign cal_hit  = step && (first_q ? (cnt_nxt == CNT_W'(PWRUP_EDGES))
                                      : (cnt_nxt == CNT_W'(RUN_EDGES)));

   // sample minus offset, one extra bit, then clamp on overflow
   always_comb begin
      diff = {samp_q[DATA_W-1], samp_q} - {offset_q[DATA_W-1], offset_q};
      if (diff[DATA_W] != diff[DATA_W-1]) corr = diff[DATA_W] ? NEG_FS : POS_FS;
      else                                corr = diff[DATA_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= M_ACQ;
         frame_q  <= 1'b0;
         first_q  <= 1'b1;
         short_q  <= 1'b0;
         cnt_q    <= '0;
         samp_q   <= '0;
         offset_q <= '0;
         result_q <= '0;
      end else if (cs_fall && !frame_q) begin
         frame_q <= 1'b1;
         cnt_q   <= '0;
         samp_q  <= core_code;
         mode_q  <= M_CONV;
      end else if (cs_rise && frame_q) begin
         frame_q <= 1'b0;
         first_q <= 1'b0;
         short_q <= (cnt_q < CNT_W'(CONV_EDGES));
         mode_q  <= M_ACQ;
      end else if (step) begin
         cnt_q <= cnt_nxt;
         if (conv_hit) begin
            result_q <= corr;
            if (!first_q) mode_q <= M_ACQ;
         end
         if (cal_hit) begin
            offset_q <= core_code;
            mode_q   <= M_CAL;
         end
      end
   end

   assign mode_o   = mode_q;
   assign frame_o  = frame_q;
   assign cnt_o    = cnt_q;
   assign result_o = result_q;
   assign short_o  = short_q;
endmodule

// File: rtl/sar_tx_shift.sv
module sar_tx_shift #(
   parameter int DATA_W = 14,
   parameter int CNT_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_fall,
   input  logic              cs_rise,
   input  logic              sclk_rise,
   input  logic [CNT_W-1:0]  edge_cnt,
   input  logic [DATA_W-1:0] result,
   input  logic              short_flag,
   output logic              sdo,
   output logic              sdo_oe,
   output logic              data_bad
);
   logic              oe_q, sdo_q, bad_q;
   logic [DATA_W-1:0] tx_q;
   logic              in_word;

   assign in_word = (edge_cnt != '0) && (edge_cnt <= CNT_W'(DATA_W));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_q  <= 1'b0;
         sdo_q <= 1'b0;
         bad_q <= 1'b0;
         tx_q  <= '0;
      end else if (cs_fall && !oe_q) begin
         oe_q  <= 1'b1;
         sdo_q <= 1'b0;
         bad_q <= short_flag;
         tx_q  <= result;
      end else if (cs_rise && oe_q) begin
         oe_q  <= 1'b0;
         sdo_q <= 1'b0;
         bad_q <= 1'b0;
      end else if (sclk_rise && oe_q) begin
         if (in_word) begin
            sdo_q <= tx_q[DATA_W-1];
            tx_q  <= {tx_q[DATA_W-2:0], 1'b0};
         end else begin
            sdo_q <= 1'b0;
         end
      end
   end

   assign sdo      = sdo_q;
   assign sdo_oe   = oe_q;
   assign data_bad = bad_q;
endmodule

// File: rtl/sar_serial_port.sv
module sar_serial_port
   import sar_port_pkg::*;
#(
   parameter int DATA_W      = 14,
   parameter int CONV_EDGES  = 18,
   parameter int PWRUP_EDGES = 24,
   parameter int RUN_EDGES   = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic [DATA_W-1:0] core_code,
   output logic              sdo,
   output logic              sdo_oe,
   output logic              data_bad,
   output logic [1:0]        mode
);
   localparam int CNT_W = $clog2(RUN_EDGES + 1);

   if (DATA_W < 2)                 begin : g_bad_w    $error("DATA_W too small");            end
   if (CONV_EDGES <= DATA_W)       begin : g_bad_conv $error("CONV_EDGES must exceed DATA_W"); end
   if (PWRUP_EDGES <= CONV_EDGES)  begin : g_bad_pwr  $error("PWRUP_EDGES must exceed CONV_EDGES"); end
   if (RUN_EDGES <= PWRUP_EDGES)   begin : g_bad_run  $error("RUN_EDGES must exceed PWRUP_EDGES"); end

   logic              cs_rise, cs_fall, sclk_rise, sclk_fall;
   logic              frame_s, short_s;
   logic [CNT_W-1:0]  cnt_s;
   logic [DATA_W-1:0] result_s;
   mode_e             mode_s;

   sar_in_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_cs_sync (
      .clk(clk), .rst_n(rst_n), .pin(cs_n), .rise(cs_rise), .fall(cs_fall));

   sar_in_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sclk_sync (
      .clk(clk), .rst_n(rst_n), .pin(sclk), .rise(sclk_rise), .fall(sclk_fall));

   sar_frame_ctrl #(
      .DATA_W(DATA_W), .CONV_EDGES(CONV_EDGES),
      .PWRUP_EDGES(PWRUP_EDGES), .RUN_EDGES(RUN_EDGES)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
      .sclk_fall(sclk_fall), .core_code(core_code), .mode_o(mode_s),
      .frame_o(frame_s), .cnt_o(cnt_s), .result_o(result_s), .short_o(short_s));

   sar_tx_shift #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
      .sclk_rise(sclk_rise), .edge_cnt(cnt_s), .result(result_s),
      .short_flag(short_s), .sdo(sdo), .sdo_oe(sdo_oe), .data_bad(data_bad));

   assign mode = mode_s;
endmodule

// File: rtl/sar_serial_port_chk.sv
module sar_serial_port_chk #(
   parameter int DATA_W      = 14,
   parameter int CONV_EDGES  = 18,
   parameter int PWRUP_EDGES = 24,
   parameter int RUN_EDGES   = 64,
   localparam int CNT_W      = $clog2(RUN_EDGES + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       mode,
   input logic             sdo,
   input logic             sdo_oe,
   input logic             frame,
   input logic [CNT_W-1:0] edge_cnt
);
   // R1: only the three defined mode codes appear
   a_r1_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
      mode != 2'b11);

   // R3: the pad is enabled exactly while the controller holds a frame open
   a_r3_oe_tracks_frame: assert property (@(posedge clk) disable iff (!rst_n)
      sdo_oe == frame);

   // R3: first value driven after enable is 0
   a_r3_leading_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdo_oe) |-> !sdo);

   // R4: once the word is out, only zeros follow
   a_r4_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (sdo_oe && edge_cnt >= CNT_W'(DATA_W + 2)) |-> !sdo);

   // R5: conversion is left only at the completion edge or at frame end
   a_r5_conv_exit: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mode == 2'b01) |-> (edge_cnt >= CNT_W'(CONV_EDGES) || !frame));

   // R7 / R8: calibration starts only on a threshold edge
   a_r7_cal_entry: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mode == 2'b10) |->
         (edge_cnt == CNT_W'(PWRUP_EDGES) || edge_cnt == CNT_W'(RUN_EDGES)));

   // R9: calibration never outlives its frame
   a_r9_cal_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10) |-> frame);
endmodule

bind sar_serial_port sar_serial_port_chk #(
   .DATA_W(DATA_W), .CONV_EDGES(CONV_EDGES),
   .PWRUP_EDGES(PWRUP_EDGES), .RUN_EDGES(RUN_EDGES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mode(mode), .sdo(sdo), .sdo_oe(sdo_oe),
   .frame(frame_s), .edge_cnt(cnt_s));

// File: tb/sar_serial_port_tb.sv
`timescale 1ns/1ps
module sar_serial_port_tb;
   localparam int CLK_PERIOD = 10;
   localparam int HALF_SCLK  = 4 * CLK_PERIOD;
   localparam int NVEC       = 12;

   // frame length, sample code, code presented during calibration
   localparam int VN [NVEC] = '{18, 20, 18, 10, 18, 18, 40, 64, 18, 18, 18, 18};
   localparam int VS [NVEC] = '{'h0123, 'h1FFF, 'h2000, 'h0555, 'h0AAA, 'h3FFF,
                                'h0001, 'h0002, 'h0015, 'h2005, 'h0000, 'h0000};
   localparam int VC [NVEC] = '{0, 0, 0, 0, 0, 0, 'h0777, 'h0010, 0, 0, 0, 0};

   logic        clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b1;
   logic [13:0] core_code = '0;
   logic        sdo, sdo_oe, data_bad;
   logic [1:0]  mode;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   logic [13:0] m_res, m_off;
   bit          m_first, m_short;

   always #(CLK_PERIOD/2) clk = ~clk;

   sar_serial_port u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .core_code(core_code),
      .sdo(sdo), .sdo_oe(sdo_oe), .data_bad(data_bad), .mode(mode));

   function automatic logic [13:0] sat_sub(input logic [13:0] a, input logic [13:0] b);
      int d;
      d = int'($signed(a)) - int'($signed(b));
      if (d > 8191)  d = 8191;
      if (d < -8192) d = -8192;
      return d[13:0];
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b1;
      #(5*CLK_PERIOD);
      rst_n = 1'b1;
      #(3*CLK_PERIOD);
      chk(mode === 2'b00,   "R1 mode after reset", mode, 0);
      chk(sdo_oe === 1'b0,  "R1 oe after reset", sdo_oe, 0);
      chk(data_bad === 1'b0,"R1 bad flag after reset", data_bad, 0);
      m_res = '0; m_off = '0; m_first = 1; m_short = 0;
   endtask

   task automatic run_frame(input int n, input logic [13:0] samp, input logic [13:0] calv);
      logic [13:0] exp_tx;
      bit          exp_bad;
      logic [63:0] got, want;
      int          thr;
      exp_tx  = m_res;
      exp_bad = m_short;
      got = '0; want = '0;
      thr = m_first ? 24 : 64;
      core_code = samp;
      #(2*CLK_PERIOD);
      cs_n = 1'b0;
      #(HALF_SCLK);
      chk(sdo_oe === 1'b1 && sdo === 1'b0, "R3 leading zero", {sdo_oe, sdo}, 2);
      chk(mode === 2'b01, "R2 conversion on frame start", mode, 1);
      chk(data_bad === exp_bad, "R6 invalid flag", data_bad, exp_bad);
      for (int k = 1; k <= n; k++) begin
         sclk = 1'b0;
         #(HALF_SCLK);
         sclk = 1'b1;
         if (k == 18) core_code = calv;
         #(HALF_SCLK);
         got[k-1]  = sdo;
         want[k-1] = (k <= 14) ? exp_tx[14-k] : 1'b0;
         if (k == 18)
            chk(mode === (m_first ? 2'b01 : 2'b00), "R5 mode after edge 18", mode,
                m_first ? 1 : 0);
         if (k == thr)
            chk(mode === 2'b10, m_first ? "R7 power-up calibration" : "R8 run-time calibration",
                mode, 2);
      end
      chk(got === want, "R4 serial word (previous result, R10 correction)", got, want);
      cs_n = 1'b1;
      #(HALF_SCLK);
      chk(sdo_oe === 1'b0, "R3 tri-state after frame", sdo_oe, 0);
      chk(mode === 2'b00, (n > 18 && n < thr) ? "R9 abort to acquisition" : "R5 acquisition",
          mode, 0);
      // model update
      if (n >= 18) begin m_res = sat_sub(samp, m_off); m_short = 0; end
      else         m_short = 1;
      if (n >= thr) m_off = calv;
      m_first = 0;
      #(HALF_SCLK);
   endtask

   initial begin
      #(1_000_000);
      if (!done) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      do_reset();
      // table walk: R1 zero first word, R2/R4/R5 streaming, R6 short frame,
      // R9 aborted run-time calibration, R8 and R10 offset with clamping
      for (int i = 0; i < NVEC; i++)
         run_frame(VN[i], VS[i][13:0], VC[i][13:0]);

      // directed: power-up calibration (R7), offset applied afterwards (R10)
      do_reset();
      run_frame(24, 14'h0040, 14'h0030);
      run_frame(18, 14'h0100, 14'h0000);
      run_frame(18, 14'h0000, 14'h0000);

      // directed: power-up calibration aborted at 23 clocks (R9), then a
      // run-time calibration at -8192 driving the result to positive clamp (R10)
      do_reset();
      run_frame(23, 14'h0200, 14'h0300);
      run_frame(24, 14'h0100, 14'h0777);
      run_frame(18, 14'h0100, 14'h0000);
      run_frame(64, 14'h0007, 14'h2000);
      run_frame(18, 14'h0005, 14'h0000);
      run_frame(18, 14'h0000, 14'h0000);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule